// File: doc/BRIEF.md
# PLL Frequency-Window Acquisition Controller

This block helps an oscillator-based phase-locked loop reach lock by measuring the oscillator digitally and pushing it toward a frequency window that depends on the selected standard. Each measurement runs a preloaded down counter, clocked by the oscillator, for a gate interval that is timed from a separate reference clock. The residue left in the counter when the gate closes is compared with a per-standard window. The block then issues an increase, decrease or no-command steering pulse, updates an in-window flag and a mute output, and starts the next measurement on its own.

The low four bits of every evaluated residue are held as a frequency-error word. That word is available both as a status field and as a parallel word for an external converter. The gate is generated in the reference domain and synchronized into the oscillator domain. The residue returns through a toggle handshake, so the evaluation never samples a counter that is still changing. A change of standard abandons the measurement in progress and starts again with the new settings.

Top module: `acq_window_ctrl`

## Requirements
- R1: While `rst_n` is low, `freq_up`, `freq_down`, `in_window`, `afc_status` and `afc_dac` are all 0, and `mute` equals `auto_mute_en`.
- R2: If the evaluated residue is above the window's upper bound, meaning the oscillator is too slow, the block issues a `freq_up` pulse and clears `in_window`.
- R3: If the evaluated residue is below the window's lower bound, meaning the oscillator is too fast, the block issues a `freq_down` pulse and clears `in_window`.
- R4: If the residue lies inside the window, the block issues neither command and sets `in_window` to 1.
- R5: For standard s (0 to 7), the counter starts at 1024+64*s and the window is inclusive: from (start − (96+16*s) − 4) to (start − (96+16*s) + 4). The gate lasts 64 reference cycles.
- R6: After each evaluation, `afc_status` holds bits [3:0] of the residue, and `afc_dac` always equals `afc_status`.
- R7: `mute` equals `auto_mute_en` AND NOT `in_window`.
- R8: A steering pulse lasts max(`hold_cycles`,1) reference cycles and does not change while it lasts. A new measurement starts as soon as the pulse ends.
- R9: A change of `std_sel` abandons the measurement in progress and discards its result. The next evaluation uses the window of the new standard.
- R10: The down counter stops at 0 instead of wrapping. A residue of 0 gives `freq_down` and `afc_status` = 0.
- R11: `freq_up` and `freq_down` are never high together, and neither is high outside a steering pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the gate and runs all sequencing |
| osc_clk | input | 1 | Oscillator under acquisition; clocks the down counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| std_sel | input | 3 | Selected standard (synchronous to ref_clk) |
| hold_cycles | input | 8 | Length of each steering pulse in reference cycles |
| auto_mute_en | input | 1 | Lets an out-of-window result drive `mute` |
| freq_up | output | 1 | Steering command: raise the oscillator frequency |
| freq_down | output | 1 | Steering command: lower the oscillator frequency |
| in_window | output | 1 | Last evaluated residue lay inside the window |
| mute | output | 1 | Mute request |
| afc_status | output | 4 | Latched low bits of the residue, for readout |
| afc_dac | output | 4 | Same latched word, for the external converter |

## Verification
The bench runs oscillator frequencies just inside the window and several counts away from each edge, across every standard. A design with the comparison reversed or off by a few counts would steer the wrong way or fail to flag lock. The bench drives an oscillator fast enough to exhaust the counter: a design that wraps would read the residue as a large value and steer upward. It changes the standard while a gate is open, with the oscillator sitting in the new standard's window. A design that kept the aborted result would emit a spurious `freq_down` pulse. It also uses zero and non-zero hold lengths, which expose an off-by-one in the pulse width. Finally it pulls reset low while a pulse is active, which exposes any command that survives reset.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_WAIT = 2'd2,
    ST_HOLD = 2'd3
  } acq_state_e;

endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/acq_std_table.sv
module acq_std_table #(
  parameter int CNT_W      = 12,
  parameter int STD_W      = 3,
  parameter int START_BASE = 1024,
  parameter int START_STEP = 64,
  parameter int TGT_BASE   = 96,
  parameter int TGT_STEP   = 16,
  parameter int WIN_HALF   = 4
) (
  input  logic [STD_W-1:0] std_i,
  output logic [CNT_W-1:0] start_o,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o
);

  localparam int N_STD = 1 << STD_W;

  logic [CNT_W-1:0] start_tab [N_STD];
  logic [CNT_W-1:0] lo_tab    [N_STD];
  logic [CNT_W-1:0] hi_tab    [N_STD];

  for (genvar s = 0; s < N_STD; s++) begin : g_std
    localparam int START_V = START_BASE + s * START_STEP;
    localparam int CENTRE  = START_V - (TGT_BASE + s * TGT_STEP);
    assign start_tab[s] = CNT_W'(START_V);
    assign lo_tab[s]    = CNT_W'(CENTRE - WIN_HALF);
    assign hi_tab[s]    = CNT_W'(CENTRE + WIN_HALF);
  end

  assign start_o = start_tab[std_i];
  assign lo_o    = lo_tab[std_i];
  assign hi_o    = hi_tab[std_i];

endmodule

// File: rtl/acq_osc_counter.sv
module acq_osc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  input  logic             gate_s,
  input  logic [CNT_W-1:0] start_i,
  output logic [CNT_W-1:0] stop_o,
  output logic             done_tgl_o
);

  logic             gate_d_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] stop_q, stop_d;
  logic             tgl_q, tgl_d;
  logic             gate_rise, gate_fall;

  assign gate_rise = gate_s & ~gate_d_q;
  assign gate_fall = ~gate_s & gate_d_q;

  always_comb begin
    cnt_d  = cnt_q;
    stop_d = stop_q;
    tgl_d  = tgl_q;
    if (gate_rise)                     cnt_d = start_i;
    else if (gate_s && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    if (gate_fall) begin
      stop_d = cnt_q;
      tgl_d  = ~tgl_q;
    end
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      gate_d_q <= 1'b0;
      cnt_q    <= '0;
      stop_q   <= '0;
      tgl_q    <= 1'b0;
    end else begin
      gate_d_q <= gate_s;
      cnt_q    <= cnt_d;
      stop_q   <= stop_d;
      tgl_q    <= tgl_d;
    end
  end

  assign stop_o     = stop_q;
  assign done_tgl_o = tgl_q;

  AST_CNT_FLOOR: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (gate_s && gate_d_q && cnt_q == '0) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int STD_W       = 3,
  parameter int HOLD_W      = 8,
  parameter int GATE_CYCLES = 64,
  parameter int AFC_W       = 4
) (
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic [STD_W-1:0]  std_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              done_s,
  input  logic [CNT_W-1:0]  stop_i,
  input  logic [CNT_W-1:0]  lo_i,
  input  logic [CNT_W-1:0]  hi_i,
  output logic              gate_o,
  output logic [STD_W-1:0]  std_q_o,
  output logic              up_o,
  output logic              down_o,
  output logic              inwin_o,
  output logic [AFC_W-1:0]  afc_o
);

  localparam int GCNT_W = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;

  acq_state_e        state_q, state_d;
  logic              gate_q, gate_d;
  logic [GCNT_W-1:0] gcnt_q, gcnt_d;
  logic [HOLD_W-1:0] hcnt_q, hcnt_d;
  logic              discard_q, discard_d;
  logic [STD_W-1:0]  std_q, std_d;
  logic              seen_q;
  logic              up_q, up_d, down_q, down_d, inwin_q, inwin_d;
  logic [AFC_W-1:0]  afc_q, afc_d;
  logic              done_evt, abort, launch, too_slow, too_fast;

  assign done_evt = done_s ^ seen_q;
  assign abort    = (std_i != std_q) && (state_q != ST_IDLE);
  assign too_slow = stop_i > hi_i;
  assign too_fast = stop_i < lo_i;

  always_comb begin
    state_d   = state_q;
    gate_d    = gate_q;
    gcnt_d    = gcnt_q;
    hcnt_d    = hcnt_q;
    discard_d = discard_q;
    std_d     = std_q;
    up_d      = up_q;
    down_d    = down_q;
    inwin_d   = inwin_q;
    afc_d     = afc_q;
    launch    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        std_d  = std_i;
        launch = 1'b1;
      end
      ST_GATE: begin
        if (gcnt_q == '0) begin
          gate_d  = 1'b0;
          state_d = ST_WAIT;
        end else begin
          gcnt_d = gcnt_q - 1'b1;
        end
      end
      ST_WAIT: begin
        if (done_evt) begin
          if (discard_q) begin
            discard_d = 1'b0;
            launch    = 1'b1;
          end else begin
            up_d    = too_slow;
            down_d  = too_fast;
            inwin_d = !too_slow && !too_fast;
            afc_d   = stop_i[AFC_W-1:0];
            hcnt_d  = hold_i;
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (hcnt_q <= HOLD_W'(1)) begin
          up_d   = 1'b0;
          down_d = 1'b0;
          launch = 1'b1;
        end else begin
          hcnt_d = hcnt_q - 1'b1;
        end
      end
      default: launch = 1'b1;
    endcase
    if (abort) begin
      std_d   = std_i;
      up_d    = 1'b0;
      down_d  = 1'b0;
      inwin_d = inwin_q;
      afc_d   = afc_q;
      if ((state_q == ST_WAIT && done_evt) || state_q == ST_HOLD) begin
        discard_d = 1'b0;
        launch    = 1'b1;
      end else begin
        discard_d = 1'b1;
      end
    end
    if (launch) begin
      state_d = ST_GATE;
      gate_d  = 1'b1;
      gcnt_d  = GCNT_W'(GATE_CYCLES - 1);
    end
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      state_q   <= ST_IDLE;
      gate_q    <= 1'b0;
      gcnt_q    <= '0;
      hcnt_q    <= '0;
      discard_q <= 1'b0;
      std_q     <= '0;
      seen_q    <= 1'b0;
      up_q      <= 1'b0;
      down_q    <= 1'b0;
      inwin_q   <= 1'b0;
      afc_q     <= '0;
    end else begin
      state_q   <= state_d;
      gate_q    <= gate_d;
      gcnt_q    <= gcnt_d;
      hcnt_q    <= hcnt_d;
      discard_q <= discard_d;
      std_q     <= std_d;
      seen_q    <= done_s;
      up_q      <= up_d;
      down_q    <= down_d;
      inwin_q   <= inwin_d;
      afc_q     <= afc_d;
    end
  end

  assign gate_o  = gate_q;
  assign std_q_o = std_q;
  assign up_o    = up_q;
  assign down_o  = down_q;
  assign inwin_o = inwin_q;
  assign afc_o   = afc_q;

  AST_CMD_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(up_q && down_q)); // R11
  AST_CMD_IN_HOLD: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (up_q || down_q) |-> (state_q == ST_HOLD)); // R11
  AST_CMD_STABLE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> ($stable(up_q) && $stable(down_q))); // R8
  AST_WINDOW_QUIET: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    inwin_q |-> !(up_q || down_q)); // R4
  AST_GATE_IN_STATE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    gate_q |-> (state_q == ST_GATE)); // R5

endmodule

// File: rtl/acq_window_ctrl.sv
module acq_window_ctrl #(
  parameter int CNT_W       = 12,
  parameter int STD_W       = 3,
  parameter int HOLD_W      = 8,
  parameter int GATE_CYCLES = 64,
  parameter int SYNC_STAGES = 2,
  parameter int START_BASE  = 1024,
  parameter int START_STEP  = 64,
  parameter int TGT_BASE    = 96,
  parameter int TGT_STEP    = 16,
  parameter int WIN_HALF    = 4
) (
  input  logic              ref_clk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic [STD_W-1:0]  std_sel,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              auto_mute_en,
  output logic              freq_up,
  output logic              freq_down,
  output logic              in_window,
  output logic              mute,
  output logic [3:0]        afc_status,
  output logic [3:0]        afc_dac
);

  localparam int AFC_W = 4;

  logic             ref_rst_n, osc_rst_n;
  logic             gate, gate_s, done_tgl, done_s;
  logic [STD_W-1:0] std_q;
  logic [CNT_W-1:0] start_v, lo_v, hi_v, stop_v;
  logic [AFC_W-1:0] afc_q;
  logic             inwin_q;

  acq_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n));
  acq_sync #(.STAGES(SYNC_STAGES)) u_osc_rst (
    .clk(osc_clk), .rst_n(rst_n), .d(1'b1), .q(osc_rst_n));
  acq_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(osc_clk), .rst_n(osc_rst_n), .d(gate), .q(gate_s));
  acq_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(done_tgl), .q(done_s));

  acq_std_table #(
    .CNT_W(CNT_W), .STD_W(STD_W), .START_BASE(START_BASE), .START_STEP(START_STEP),
    .TGT_BASE(TGT_BASE), .TGT_STEP(TGT_STEP), .WIN_HALF(WIN_HALF)
  ) u_table (
    .std_i(std_q), .start_o(start_v), .lo_o(lo_v), .hi_o(hi_v));

  acq_osc_counter #(.CNT_W(CNT_W)) u_counter (
    .osc_clk(osc_clk), .osc_rst_n(osc_rst_n), .gate_s(gate_s), .start_i(start_v),
    .stop_o(stop_v), .done_tgl_o(done_tgl));

  acq_seq #(
    .CNT_W(CNT_W), .STD_W(STD_W), .HOLD_W(HOLD_W), .GATE_CYCLES(GATE_CYCLES), .AFC_W(AFC_W)
  ) u_seq (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .std_i(std_sel), .hold_i(hold_cycles),
    .done_s(done_s), .stop_i(stop_v), .lo_i(lo_v), .hi_i(hi_v), .gate_o(gate),
    .std_q_o(std_q), .up_o(freq_up), .down_o(freq_down), .inwin_o(inwin_q), .afc_o(afc_q));

  assign in_window  = inwin_q;
  assign mute       = auto_mute_en & ~inwin_q;
  assign afc_status = afc_q;
  assign afc_dac    = afc_q;

endmodule

// File: tb/tb_acq_window_ctrl.sv
`timescale 1ns/1ps
module tb_acq_window_ctrl;

  logic       ref_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst_n;
  logic [2:0] std_sel;
  logic [7:0] hold_cycles;
  logic       auto_mute_en;
  logic       freq_up, freq_down, in_window, mute;
  logic [3:0] afc_status, afc_dac;

  real osc_half = 1.5;
  int  checks = 0;
  int  fails  = 0;

  acq_window_ctrl dut (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n), .std_sel(std_sel),
    .hold_cycles(hold_cycles), .auto_mute_en(auto_mute_en), .freq_up(freq_up),
    .freq_down(freq_down), .in_window(in_window), .mute(mute),
    .afc_status(afc_status), .afc_dac(afc_dac));

  always #2 ref_clk = ~ref_clk;
  always #(osc_half) osc_clk = ~osc_clk;

  function automatic int start_of(input int s); return 1024 + 64 * s; endfunction
  function automatic int centre_of(input int s); return start_of(s) - (96 + 16 * s); endfunction
  function automatic int stop_of(input int s, input int n);
    return (n >= start_of(s)) ? 0 : start_of(s) - n;
  endfunction
  // 1 = raise, 2 = lower, 0 = inside
  function automatic int class_of(input int s, input int stop);
    if (stop > centre_of(s) + 4) return 1;
    if (stop < centre_of(s) - 4) return 2;
    return 0;
  endfunction
  function automatic bit afc_ok(input int s, input int n, input int afc);
    bit ok = 1'b0;
    for (int d = -3; d <= 3; d++) if ((stop_of(s, n + d) % 16) == afc) ok = 1'b1;
    return ok;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int s, input int n, input int h, input bit en);
    int  cls, stp, up_w, dn_w, afc_at, win_at;
    bit  seen;
    @(negedge ref_clk);
    std_sel = 3'(s); hold_cycles = 8'(h); auto_mute_en = en;
    osc_half = 128.0 / n;
    repeat (2 * (90 + h)) @(negedge ref_clk);
    stp = stop_of(s, n);
    cls = class_of(s, stp);
    up_w = 0; dn_w = 0; seen = 1'b0; afc_at = 0; win_at = 0;
    for (int i = 0; i < 100 + h && !seen; i++) begin
      @(negedge ref_clk);
      if (freq_up || freq_down) begin
        seen   = 1'b1;
        afc_at = int'(afc_status);
        win_at = int'(in_window);
        chk(afc_dac == afc_status, "R6", "dac word", afc_dac, afc_status);
        chk(mute == (en & ~in_window), "R7", "mute during pulse", mute, en & ~in_window);
        while (freq_up || freq_down) begin
          chk(!(freq_up && freq_down), "R11", "both commands", 1, 0);
          if (freq_up) up_w++;
          if (freq_down) dn_w++;
          @(negedge ref_clk);
        end
      end
    end
    if (cls == 1) begin
      chk(seen && dn_w == 0 && up_w > 0, "R2", "raise command width", up_w, (h > 0) ? h : 1);
      chk(up_w == ((h > 0) ? h : 1), "R8", "pulse width", up_w, (h > 0) ? h : 1);
      chk(win_at == 0, "R2", "in_window", win_at, 0);
    end else if (cls == 2) begin
      chk(seen && up_w == 0 && dn_w > 0, (stp == 0) ? "R10" : "R3", "lower command width",
          dn_w, (h > 0) ? h : 1);
      chk(dn_w == ((h > 0) ? h : 1), "R8", "pulse width", dn_w, (h > 0) ? h : 1);
      chk(win_at == 0, "R3", "in_window", win_at, 0);
    end else begin
      chk(!seen, "R4", "command while inside", up_w + dn_w, 0);
      chk(in_window == 1'b1, "R5", "in_window", in_window, 1);
      afc_at = int'(afc_status);
      chk(afc_dac == afc_status, "R6", "dac word", afc_dac, afc_status);
    end
    if (stp == 0) chk(afc_at == 0, "R10", "afc at floor", afc_at, 0);
    else          chk(afc_ok(s, n, afc_at), "R6", "afc low bits", afc_at, stp % 16);
    chk(mute == (en & ~in_window), "R7", "mute", mute, en & ~in_window);
  endtask

  task automatic abort_case();
    int up_w, dn_w;
    bit seen;
    @(negedge ref_clk);
    std_sel = 3'd0; hold_cycles = 8'd2; auto_mute_en = 1'b1;
    osc_half = 128.0 / 208;
    repeat (200) @(negedge ref_clk);
    seen = 1'b0;
    for (int i = 0; i < 150 && !seen; i++) begin
      @(negedge ref_clk);
      if (freq_down) seen = 1'b1;
    end
    chk(seen, "R3", "lower command before switch", seen, 1);
    while (freq_down) @(negedge ref_clk);
    repeat (20) @(negedge ref_clk);
    std_sel = 3'd7;
    up_w = 0; dn_w = 0;
    for (int i = 0; i < 220; i++) begin
      @(negedge ref_clk);
      if (freq_up) up_w++;
      if (freq_down) dn_w++;
    end
    chk(up_w == 0 && dn_w == 0, "R9", "commands after abort", up_w + dn_w, 0);
    chk(in_window == 1'b1, "R9", "in_window on new standard", in_window, 1);
    chk(afc_ok(7, 208, int'(afc_status)), "R9", "afc of new standard", afc_status,
        stop_of(7, 208) % 16);
  endtask

  task automatic reset_checks(input bit en);
    chk(freq_up == 1'b0 && freq_down == 1'b0, "R1", "commands in reset", {freq_up, freq_down}, 0);
    chk(in_window == 1'b0, "R1", "in_window in reset", in_window, 0);
    chk(afc_status == 4'd0 && afc_dac == 4'd0, "R1", "afc in reset", afc_status, 0);
    chk(mute == en, "R1", "mute in reset", mute, en);
  endtask

  initial begin
    repeat (190000) @(posedge ref_clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned r;
    int s, n, h;
    void'($urandom(32'd7351));
    rst_n = 1'b0; std_sel = 3'd0; hold_cycles = 8'd1; auto_mute_en = 1'b1;
    repeat (6) @(negedge ref_clk);
    reset_checks(1'b1);
    rst_n = 1'b1;

    run_case(0, 96, 3, 1'b1);    // R4 R5 inside
    run_case(0, 60, 0, 1'b1);    // R2 slow, width 1
    run_case(0, 140, 5, 1'b1);   // R3 fast
    run_case(0, 1280, 2, 1'b1);  // R10 counter floor
    run_case(3, 120, 4, 1'b0);   // R7 mute disabled, raise
    run_case(7, 208, 1, 1'b1);   // R5 top standard inside
    abort_case();                // R9

    for (int it = 0; it < 12; it++) begin
      s = int'($urandom % 8);
      h = int'($urandom % 12);
      r = $urandom % 3;
      if (r == 0)      n = 96 + 16 * s;
      else if (r == 1) n = 96 + 16 * s - 8 - int'($urandom % 40);
      else             n = 96 + 16 * s + 8 + int'($urandom % 60);
      run_case(s, n, h, 1'($urandom % 2));
    end

    // R1: reset asserted while a lower command is being issued
    @(negedge ref_clk);
    std_sel = 3'd0; hold_cycles = 8'd6; auto_mute_en = 1'b0; osc_half = 128.0 / 150;
    repeat (250) @(negedge ref_clk);
    while (!freq_down) @(negedge ref_clk);
    #1 rst_n = 1'b0;
    #1 reset_checks(1'b0);
    repeat (3) @(negedge ref_clk);
    reset_checks(1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge ref_clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule